// File: doc/BRIEF.md
# Local Interrupt Vector Dispatcher

This block keeps the local vector table entries of one processor's interrupt controller: one for the legacy interrupt line (LINT0), one for the second local line (LINT1) and one for the timer. Each local event reads the entry that belongs to its source. A single decode path then turns the event into one of four results: a system-management request, a non-maskable request, an external (hard) interrupt request, or a fixed vector. A fixed vector goes to the pending-interrupt logic together with an edge or level trigger flag.

The block also decides whether a request from the external legacy interrupt controller is taken. It gives the LINT0 entry its reset value, which depends on the processor ID. Software loads the entries through a simple write port. When several sources fire together, they are served one per cycle in a fixed priority order, and the sources that lose wait in pending bits.

Top module: `lvd_dispatch`

## Requirements
- R1: At reset the timer entry (select 2) and the LINT1 entry (select 1) become 0x0001_0000, which is masked. The LINT0 entry (select 0) becomes 0x0000_0700 (ExtInt, unmasked) when `cpu_id` is 0, and 0x0001_0000 otherwise.
- R2: When bit 16 (mask) of the served entry is set, the event is dropped and no output pulses.
- R3: The delivery mode is read from entry bits 10:8. The codes are 000 Fixed, 010 SMI, 100 NMI and 111 ExtInt.
- R4: The SMI, NMI and ExtInt modes pulse `smi_req`, `nmi_req` or `extint_req` respectively. The pulse is exactly one cycle long and appears in the cycle after a lone source event.
- R5: Fixed mode pulses `fix_valid` for one cycle, with entry bits 7:0 on `fix_vector`.
- R6: A Fixed delivery raises `fix_level` only when the source is LINT0 or LINT1 and entry bit 15 is set. Timer deliveries are always edge (`fix_level` = 0).
- R7: A timer event (`timer_fire`) is decoded through the same mode path as the LINT sources, so any of the four modes applies to it.
- R8: `legacy_accept` is high when `apic_en` is low or when the LINT0 mask bit is clear. A legacy request made while it is low produces no output.
- R9: A legacy request (`pic_req`) with `pic_level` low produces no output.
- R10: The mode codes 001, 011, 101 and 110 produce no output.
- R11: Events that arrive together are served one per cycle in the order LINT0, then LINT1, then timer. Events that lose are held and delivered in the following cycles. At most one output pulses per cycle.
- R12: A write with `wr_en` high loads `wr_data` into the entry chosen by `wr_sel` at the clock edge. `wr_sel` = 3 changes no entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_id | input | ID_W (8) | Processor ID strap, used for the LINT0 reset value |
| apic_en | input | 1 | Global controller enable bit |
| wr_en | input | 1 | Entry write strobe |
| wr_sel | input | 2 | Entry select: 0 LINT0, 1 LINT1, 2 timer |
| wr_data | input | 32 | Entry write value |
| timer_fire | input | 1 | Timer event strobe |
| lint1_fire | input | 1 | LINT1 event strobe |
| pic_req | input | 1 | Legacy controller request strobe |
| pic_level | input | 1 | Level carried with the legacy request |
| legacy_accept | output | 1 | Legacy requests are currently taken |
| smi_req | output | 1 | SMI request pulse to the core |
| nmi_req | output | 1 | NMI request pulse to the core |
| extint_req | output | 1 | Hard-interrupt request pulse to the core |
| fix_valid | output | 1 | Fixed vector strobe to the pending logic |
| fix_vector | output | 8 | Fixed vector number |
| fix_level | output | 1 | Trigger of the fixed vector: 1 level, 0 edge |

## Verification
The properties assume that the event strobes are synchronous to `clk` and that `cpu_id` stays constant while reset is released. They also assume that a source does not fire again while its earlier event is still pending, since such an event would be merged into the pending one. The stimulus changes `cpu_id` only while reset is held, and it drives each event burst as one single-cycle strobe. It then leaves idle cycles so that every pending event drains before the next burst or entry write.

// File: rtl/lvd_pkg.sv
package lvd_pkg;
    localparam int LVT_W     = 32;
    localparam int VEC_W     = 8;
    localparam int NUM_SRC   = 3;
    localparam int SEL_W     = 2;
    localparam int SRC_LINT0 = 0;
    localparam int SRC_LINT1 = 1;
    localparam int SRC_TIMER = 2;
    localparam int MASK_BIT  = 16;
    localparam int TRIG_BIT  = 15;
    localparam int MODE_LO   = 8;
    localparam int MODE_W    = 3;

    localparam logic [LVT_W-1:0] LVT_RST_MASKED = 32'h0001_0000;
    localparam logic [LVT_W-1:0] LVT_RST_EXTINT = 32'h0000_0700;

    typedef enum logic [MODE_W-1:0] {
        DM_FIXED  = 3'b000,
        DM_SMI    = 3'b010,
        DM_NMI    = 3'b100,
        DM_EXTINT = 3'b111
    } dmode_e;

    typedef struct packed {
        logic             smi;
        logic             nmi;
        logic             ext;
        logic             fix;
        logic [VEC_W-1:0] vec;
        logic             lvl;
    } dout_t;
endpackage

// File: rtl/lvd_lvt_file.sv
module lvd_lvt_file
    import lvd_pkg::*;
#(
    parameter int N    = NUM_SRC,
    parameter int W    = LVT_W,
    parameter int ID_W = 8,
    parameter int SW   = SEL_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [ID_W-1:0]       cpu_id,
    input  logic                  wr_en,
    input  logic [SW-1:0]         wr_sel,
    input  logic [W-1:0]          wr_data,
    output logic [N-1:0][W-1:0]   ent_o
);
    typedef struct packed {
        logic [N-1:0][W-1:0] ent;
    } state_t;

    state_t s_d, s_q;
    logic [N-1:0][W-1:0] rst_val;

    // LINT0 reset value depends on the processor ID; all others start masked
    for (genvar g = 0; g < N; g++) begin : g_rst
        if (g == SRC_LINT0) begin : g_lint0
            assign rst_val[g] = (cpu_id == '0) ? W'(LVT_RST_EXTINT) : W'(LVT_RST_MASKED);
        end else begin : g_other
            assign rst_val[g] = W'(LVT_RST_MASKED);
        end
    end

    always_comb begin
        s_d = s_q;
        if (wr_en) begin
            for (int i = 0; i < N; i++) begin
                if (wr_sel == SW'(i)) s_d.ent[i] = wr_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q.ent <= rst_val;
        else        s_q     <= s_d;
    end

    assign ent_o = s_q.ent;
endmodule

// File: rtl/lvd_arb.sv
module lvd_arb #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] raise_i,
    output logic [N-1:0] gnt_o,
    output logic         pend_any_o
);
    typedef struct packed {
        logic [N-1:0] pend;
    } state_t;

    state_t s_d, s_q;
    logic [N-1:0] req;
    logic [N-1:0] higher;

    assign req = s_q.pend | raise_i;

    // lowest index has the highest priority
    for (genvar g = 0; g < N; g++) begin : g_prio
        if (g == 0) begin : g_first
            assign higher[g] = 1'b0;
        end else begin : g_rest
            assign higher[g] = higher[g-1] | req[g-1];
        end
        assign gnt_o[g] = req[g] & ~higher[g];
    end

    always_comb begin
        s_d      = s_q;
        s_d.pend = req & ~gnt_o;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign pend_any_o = |s_q.pend;
endmodule

// File: rtl/lvd_decode.sv
module lvd_decode
    import lvd_pkg::*;
#(
    parameter int N = NUM_SRC,
    parameter int W = LVT_W,
    parameter logic [N-1:0] LVL_OK = N'((1 << SRC_LINT0) | (1 << SRC_LINT1))
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [N-1:0]        gnt_i,
    input  logic [N-1:0][W-1:0] ent_i,
    output dout_t               dout_o
);
    dout_t              d_d, d_q;
    logic [W-1:0]       sel;
    logic               lvl_ok;
    logic [MODE_W-1:0]  mode;
    logic               unused_bits;

    always_comb begin
        sel = '0;
        for (int i = 0; i < N; i++) begin
            if (gnt_i[i]) sel = sel | ent_i[i];
        end
    end

    assign lvl_ok      = |(gnt_i & LVL_OK);
    assign mode        = sel[MODE_LO +: MODE_W];
    assign unused_bits = ^{sel[W-1:MASK_BIT+1], sel[TRIG_BIT-1:MODE_LO+MODE_W]};

    always_comb begin
        d_d = '0;
        if (|gnt_i && !sel[MASK_BIT]) begin
            case (mode)
                DM_SMI:    d_d.smi = 1'b1;
                DM_NMI:    d_d.nmi = 1'b1;
                DM_EXTINT: d_d.ext = 1'b1;
                DM_FIXED: begin
                    d_d.fix = 1'b1;
                    d_d.vec = sel[VEC_W-1:0];
                    d_d.lvl = lvl_ok & sel[TRIG_BIT];
                end
                default: d_d = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) d_q <= '0;
        else        d_q <= d_d;
    end

    assign dout_o = d_q;
endmodule

// File: rtl/lvd_dispatch.sv
module lvd_dispatch
    import lvd_pkg::*;
#(
    parameter int ID_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ID_W-1:0]   cpu_id,
    input  logic              apic_en,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [LVT_W-1:0]  wr_data,
    input  logic              timer_fire,
    input  logic              lint1_fire,
    input  logic              pic_req,
    input  logic              pic_level,
    output logic              legacy_accept,
    output logic              smi_req,
    output logic              nmi_req,
    output logic              extint_req,
    output logic              fix_valid,
    output logic [VEC_W-1:0]  fix_vector,
    output logic              fix_level
);
    logic [NUM_SRC-1:0][LVT_W-1:0] ent;
    logic [NUM_SRC-1:0]            raise;
    logic [NUM_SRC-1:0]            gnt;
    logic                          pend_any;
    dout_t                         dout;

    lvd_lvt_file #(.N(NUM_SRC), .W(LVT_W), .ID_W(ID_W), .SW(SEL_W)) file_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .cpu_id  (cpu_id),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .ent_o   (ent)
    );

    assign legacy_accept     = ~apic_en | ~ent[SRC_LINT0][MASK_BIT];
    assign raise[SRC_LINT0]  = pic_req & pic_level & legacy_accept;
    assign raise[SRC_LINT1]  = lint1_fire;
    assign raise[SRC_TIMER]  = timer_fire;

    lvd_arb #(.N(NUM_SRC)) arb_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .raise_i    (raise),
        .gnt_o      (gnt),
        .pend_any_o (pend_any)
    );

    lvd_decode #(.N(NUM_SRC), .W(LVT_W)) dec_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .gnt_i  (gnt),
        .ent_i  (ent),
        .dout_o (dout)
    );

    assign smi_req    = dout.smi;
    assign nmi_req    = dout.nmi;
    assign extint_req = dout.ext;
    assign fix_valid  = dout.fix;
    assign fix_vector = dout.vec;
    assign fix_level  = dout.lvl;
endmodule

// File: rtl/lvd_dispatch_chk.sv
module lvd_dispatch_chk #(
    parameter int N = 3
) (
    input logic         clk,
    input logic         rst_n,
    input logic         apic_en,
    input logic         legacy_accept,
    input logic         smi_req,
    input logic         nmi_req,
    input logic         extint_req,
    input logic         fix_valid,
    input logic         fix_level,
    input logic         timer_fire,
    input logic         lint1_fire,
    input logic         pic_req,
    input logic         pend_any,
    input logic [N-1:0] gnt
);
    // R11: never more than one result per cycle
    assert_single_output_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({smi_req, nmi_req, extint_req, fix_valid}));

    // R11: the arbiter serves one source per cycle
    assert_single_grant_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt));

    // R4: an output only follows an event or a held pending event
    assert_output_has_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (smi_req || nmi_req || extint_req || fix_valid) |->
        $past(timer_fire || lint1_fire || pic_req || pend_any));

    // R8: a disabled controller always takes legacy requests
    assert_accept_when_disabled_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !apic_en |-> legacy_accept);

    // R6: the trigger flag only travels with a fixed vector
    assert_level_with_fixed_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fix_level |-> fix_valid);

    // R6: a timer delivery is always edge triggered
    assert_timer_edge_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt == N'(1 << (N-1))) |=> !fix_level);
endmodule

bind lvd_dispatch lvd_dispatch_chk #(.N(lvd_pkg::NUM_SRC)) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .apic_en       (apic_en),
    .legacy_accept (legacy_accept),
    .smi_req       (smi_req),
    .nmi_req       (nmi_req),
    .extint_req    (extint_req),
    .fix_valid     (fix_valid),
    .fix_level     (fix_level),
    .timer_fire    (timer_fire),
    .lint1_fire    (lint1_fire),
    .pic_req       (pic_req),
    .pend_any      (pend_any),
    .gnt           (gnt)
);

// File: tb/lvd_dispatch_tb.sv
module lvd_dispatch_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  cpu_id = 8'd0;
    logic        apic_en = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [31:0] wr_data = 32'd0;
    logic        timer_fire = 1'b0;
    logic        lint1_fire = 1'b0;
    logic        pic_req = 1'b0;
    logic        pic_level = 1'b0;
    logic        legacy_accept, smi_req, nmi_req, extint_req, fix_valid, fix_level;
    logic [7:0]  fix_vector;

    always #(CLK_PERIOD/2) clk = ~clk;

    lvd_dispatch dut_i (
        .clk(clk), .rst_n(rst_n), .cpu_id(cpu_id), .apic_en(apic_en),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .timer_fire(timer_fire), .lint1_fire(lint1_fire),
        .pic_req(pic_req), .pic_level(pic_level),
        .legacy_accept(legacy_accept), .smi_req(smi_req), .nmi_req(nmi_req),
        .extint_req(extint_req), .fix_valid(fix_valid),
        .fix_vector(fix_vector), .fix_level(fix_level)
    );

    typedef struct {
        int          cyc;
        logic        smi, nmi, ext, fix, lvl;
        logic [7:0]  vec;
        string       tag;
    } exp_t;

    exp_t        sb[$];
    int          total = 0;
    int          fails = 0;
    int          cyc = 0;
    logic [31:0] m_ent [3];   // index 0 LINT0, 1 LINT1, 2 timer

    always @(posedge clk) cyc <= cyc + 1;

    function automatic exp_t calc(int src, logic [31:0] e, int c, string tag);
        exp_t x;
        x.cyc = c; x.tag = tag;
        x.smi = 0; x.nmi = 0; x.ext = 0; x.fix = 0; x.lvl = 0; x.vec = 8'd0;
        if (!e[16]) begin
            case (e[10:8])
                3'b010: x.smi = 1;
                3'b100: x.nmi = 1;
                3'b111: x.ext = 1;
                3'b000: begin
                    x.fix = 1;
                    x.vec = e[7:0];
                    x.lvl = (src != 2) && e[15];
                end
                default: ;
            endcase
        end
        return x;
    endfunction

    // monitor: compare each expected item in its own cycle
    initial begin
        forever begin
            @(negedge clk);
            if (sb.size() > 0 && sb[0].cyc == cyc) begin
                exp_t e;
                e = sb.pop_front();
                total++;
                if ({smi_req, nmi_req, extint_req, fix_valid, fix_level, fix_vector} !==
                    {e.smi, e.nmi, e.ext, e.fix, e.lvl, e.vec}) begin
                    fails++;
                    $display("FAIL %s: got smi=%0b nmi=%0b ext=%0b fix=%0b lvl=%0b vec=%02h, expected smi=%0b nmi=%0b ext=%0b fix=%0b lvl=%0b vec=%02h",
                             e.tag, smi_req, nmi_req, extint_req, fix_valid, fix_level, fix_vector,
                             e.smi, e.nmi, e.ext, e.fix, e.lvl, e.vec);
                end
            end else if (rst_n && (smi_req || nmi_req || extint_req || fix_valid)) begin
                total++; fails++;
                $display("FAIL R11: unexpected output smi=%0b nmi=%0b ext=%0b fix=%0b, expected none",
                         smi_req, nmi_req, extint_req, fix_valid);
            end
        end
    end

    task automatic check_bit(string tag, logic got, logic exp);
        total++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %0b, expected %0b", tag, got, exp);
        end
    endtask

    task automatic do_reset(logic [7:0] id);
        @(negedge clk);
        rst_n = 1'b0; cpu_id = id;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        m_ent[0] = (id == 8'd0) ? 32'h0000_0700 : 32'h0001_0000;
        m_ent[1] = 32'h0001_0000;
        m_ent[2] = 32'h0001_0000;
    endtask

    task automatic write_ent(logic [1:0] sel, logic [31:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
        if (sel != 2'd3) m_ent[sel] = data;
    endtask

    // driver: one burst of events, expected results queued in service order
    task automatic fire(bit t, bit l1, bit pr, bit pl, string tag);
        int k;
        @(negedge clk);
        timer_fire = t; lint1_fire = l1; pic_req = pr; pic_level = pl;
        k = 0;
        if (pr && pl && (!apic_en || !m_ent[0][16])) begin
            sb.push_back(calc(0, m_ent[0], cyc + 1 + k, tag)); k++;
        end
        if (l1) begin sb.push_back(calc(1, m_ent[1], cyc + 1 + k, tag)); k++; end
        if (t)  begin sb.push_back(calc(2, m_ent[2], cyc + 1 + k, tag)); k++; end
        if (k == 0) sb.push_back(calc(0, 32'h0001_0000, cyc + 1, tag));
        @(negedge clk);
        timer_fire = 0; lint1_fire = 0; pic_req = 0; pic_level = 0;
        repeat (4) @(negedge clk);
    endtask

    task automatic summary;
        $display("%0d/%0d checks passed", total - fails, total);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        total++; fails++;
        $display("FAIL watchdog: run did not finish, got timeout, expected completion");
        summary();
        $finish;
    end

    initial begin
        // R1: processor 0 reset state
        do_reset(8'd0);
        check_bit("R1 lint0 unmasked on id 0", legacy_accept, 1'b1);
        fire(0, 0, 1, 1, "R1 lint0 ExtInt after reset");
        fire(1, 0, 0, 0, "R1 timer masked after reset");
        fire(0, 1, 0, 0, "R1 lint1 masked after reset");

        // R7 R3 R4: timer through the common decode
        write_ent(2'd2, 32'h0000_0200);
        fire(1, 0, 0, 0, "R7 timer SMI");
        write_ent(2'd1, 32'h0000_0400);
        fire(0, 1, 0, 0, "R4 lint1 NMI");
        write_ent(2'd2, 32'h0000_0700);
        fire(1, 0, 0, 0, "R3 timer ExtInt");

        // R5 R6: fixed vectors and trigger
        write_ent(2'd1, 32'h0000_805A);
        fire(0, 1, 0, 0, "R6 lint1 fixed level");
        write_ent(2'd1, 32'h0000_003C);
        fire(0, 1, 0, 0, "R5 lint1 fixed edge");
        write_ent(2'd2, 32'h0000_8031);
        fire(1, 0, 0, 0, "R6 timer fixed stays edge");
        write_ent(2'd0, 32'h0000_8077);
        fire(0, 0, 1, 1, "R6 lint0 fixed level");

        // R9: deasserted legacy level
        fire(0, 0, 1, 0, "R9 legacy level low ignored");

        // R10: unused mode codes
        for (int m = 1; m < 7; m++) begin
            if (m == 2 || m == 4) continue;
            write_ent(2'd1, {21'd0, 3'(m), 8'h11});
            fire(0, 1, 0, 0, "R10 unused mode silent");
        end

        // R2: masked entry drops the event
        write_ent(2'd1, 32'h0001_0400);
        fire(0, 1, 0, 0, "R2 masked lint1 NMI dropped");

        // R11: simultaneous sources
        write_ent(2'd1, 32'h0000_0400);
        write_ent(2'd2, 32'h0000_0200);
        fire(1, 1, 1, 1, "R11 priority order");

        // R12: select 3 writes nothing
        write_ent(2'd3, 32'h0001_0000);
        fire(1, 1, 1, 1, "R12 select 3 ignored");

        // R1 R8: nonzero processor ID
        do_reset(8'd5);
        check_bit("R1 lint0 masked on id 5", legacy_accept, 1'b0);
        fire(0, 0, 1, 1, "R8 rejected legacy request");
        @(negedge clk); apic_en = 1'b0;
        @(negedge clk);
        check_bit("R8 accept when disabled", legacy_accept, 1'b1);
        fire(0, 0, 1, 1, "R2 accepted but masked");
        @(negedge clk); apic_en = 1'b1;
        write_ent(2'd0, 32'h0000_0700);
        @(negedge clk);
        check_bit("R8 accept when lint0 unmasked", legacy_accept, 1'b1);
        fire(0, 0, 1, 1, "R8 accepted ExtInt");

        repeat (4) @(negedge clk);
        check_bit("R11 all expected results seen", sb.size() == 0, 1'b1);
        summary();
        $finish;
    end
endmodule